// File: doc/BRIEF.md
# XY Mesh Route Computation Unit

This block is the route-computation stage of a router placed in a two-dimensional mesh of `MESH_X` by `MESH_Y` nodes. It is given the coordinates of its current position and the destination coordinates from a packet header, and picks one of five output ports. The packet first travels along X, toward larger or smaller X, until its X coordinate equals the destination X. Only then does it travel along Y until the destination Y is reached. For each hop the block also reports the number of the unidirectional link used. These numbers are assigned so that every dependence an X-then-Y path can create runs from a smaller number to a larger one. That ordering is what makes this routing free of deadlock.

A hop-sequencing wrapper loads a source and destination and then steps the header through the mesh, one hop per clock cycle, until it arrives. It counts the hops and compares the count with the Manhattan distance between source and destination. It also checks that each hop's link number is strictly larger than the previous hop's link number. Coordinates are unsigned, with 0 at the low edge of each axis. Inputs are assumed to be inside the mesh.

Top module: `mesh_xy_walker`

## Requirements
- R1: While the current X differs from the destination X, the hop port is +X (code 1) when the destination X is larger and −X (code 2) when it is smaller. No Y port is chosen before the X coordinates match.
- R2: Once the X coordinates match, the hop port is +Y (code 3) when the destination Y is larger and −Y (code 4) when it is smaller.
- R3: When the current position equals the destination, the port is local (code 0) and `hop_valid` is low. On the next edge `busy` falls and `done` is high for exactly one cycle.
- R4: Exactly one hop is taken per cycle while `busy` is high and not yet arrived. Each hop changes one coordinate by one. `done` appears L+1 cycles after the start is accepted, where L = |sx−dx| + |sy−dy|.
- R5: The link number of an X hop taken from column x is x+1 for a +X hop and MESH_X−x−1 for a −X hop.
- R6: The link number of a Y hop taken from row y is y+MESH_X for a +Y hop and MESH_X+MESH_Y−y for a −Y hop.
- R7: Along each path the link numbers rise strictly. `order_violation` is a sticky flag, cleared by an accepted start, that is set if a hop's number does not exceed the previous hop's number.
- R8: At completion `hop_count` equals the Manhattan distance L. `path_mismatch` is set at completion when the two differ, and is cleared by an accepted start.
- R9: A `start` pulse while `busy` is high is ignored: the running path keeps its destination and hop count.
- R10: After reset, `busy`, `done`, `hop_count`, `path_mismatch` and `order_violation` are all 0.
- R11: An accepted start places the current position at the source on the next edge. When the source equals the destination, `done` follows one cycle later with `hop_count` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load source and destination when idle |
| src_x | input | XW | Source column |
| src_y | input | YW | Source row |
| dst_x | input | XW | Destination column |
| dst_y | input | YW | Destination row |
| busy | output | 1 | A path is being walked |
| done | output | 1 | One-cycle pulse on arrival |
| cur_x | output | XW | Current column of the header |
| cur_y | output | YW | Current row of the header |
| hop_valid | output | 1 | A hop is taken at the coming edge |
| out_port | output | 3 | Chosen port: 0 local, 1 +X, 2 −X, 3 +Y, 4 −Y |
| link_num | output | LW | Number of the link the chosen hop uses |
| hop_count | output | HW | Hops taken on the current path |
| path_mismatch | output | 1 | Hop count differed from Manhattan distance |
| order_violation | output | 1 | Link numbers failed to rise strictly |

XW = max(1, ceil(log2 MESH_X)), YW = max(1, ceil(log2 MESH_Y)), LW = ceil(log2(MESH_X+MESH_Y)), HW = ceil(log2(MESH_X+MESH_Y−1)).

## Verification
The bench builds the block with MESH_X = 6 and MESH_Y = 5. Neither dimension is a power of two, so the coordinate fields have unused codes and the mesh is not square. With these values the corner-to-corner paths reach both link number 0 and the top number 10, and they cross the boundary between the X numbers (up to 5) and the Y numbers (from 6). The bench also walks single-axis paths and zero-length paths, sends a second start in the middle of a path, and runs seeded random source and destination pairs.

// File: rtl/mesh_route_pkg.sv
// Shared types for the XY mesh route computation.
// Assumes: a five-port router (local plus four mesh directions).
package mesh_route_pkg;

    // Output port codes; the numeric values are visible on out_port.
    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_XPOS  = 3'd1,
        PORT_XNEG  = 3'd2,
        PORT_YPOS  = 3'd3,
        PORT_YNEG  = 3'd4
    } port_e;

endpackage

// File: rtl/xy_port_select.sv
// Dimension-ordered port choice: X is corrected first, then Y.
// Assumes both coordinate pairs are inside the mesh.
module xy_port_select
    import mesh_route_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output port_e         port_sel,
    output logic          arrived
);

    // Pick the port from the coordinate comparison, X axis first.
    always_comb begin
        arrived = 1'b0;
        if (cur_x < dst_x) begin
            port_sel = PORT_XPOS;
        end else if (cur_x > dst_x) begin
            port_sel = PORT_XNEG;
        end else if (cur_y < dst_y) begin
            port_sel = PORT_YPOS;
        end else if (cur_y > dst_y) begin
            port_sel = PORT_YNEG;
        end else begin
            port_sel = PORT_LOCAL;
            arrived  = 1'b1;
        end
    end

endmodule

// File: rtl/xy_link_index.sv
// Deadlock-ordering number of the unidirectional link a hop uses.
// Assumes the port never points off the mesh edge (guaranteed by XY choice).
module xy_link_index
    import mesh_route_pkg::*;
#(
    parameter int MESH_X = 6,
    parameter int MESH_Y = 5,
    parameter int XW     = 3,
    parameter int YW     = 3,
    parameter int LW     = 4
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  port_e         port_sel,
    output logic [LW-1:0] link
);

    localparam logic [LW-1:0] X_HIGH  = LW'(MESH_X - 1);
    localparam logic [LW-1:0] Y_BASE  = LW'(MESH_X);
    localparam logic [LW-1:0] Y_NEG_T = LW'(MESH_X + MESH_Y);

    logic [LW-1:0] x_wide;
    logic [LW-1:0] y_wide;

    // Widen coordinates to the link number width.
    always_comb begin
        x_wide = LW'(cur_x);
        y_wide = LW'(cur_y);
    end

    // Map the hop direction and position to its link number.
    always_comb begin
        unique case (port_sel)
            PORT_XPOS: link = x_wide + LW'(1);
            PORT_XNEG: link = X_HIGH - x_wide;
            PORT_YPOS: link = y_wide + Y_BASE;
            PORT_YNEG: link = Y_NEG_T - y_wide;
            default:   link = '0;
        endcase
    end

endmodule

// File: rtl/xy_route_unit.sv
// Route-computation stage: port choice plus link number for one header.
// Purely combinational; the caller registers position and destination.
module xy_route_unit
    import mesh_route_pkg::*;
#(
    parameter int MESH_X = 6,
    parameter int MESH_Y = 5,
    parameter int XW     = 3,
    parameter int YW     = 3,
    parameter int LW     = 4
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output port_e         port_sel,
    output logic          arrived,
    output logic [LW-1:0] link
);

    xy_port_select #(.XW(XW), .YW(YW)) u_sel (
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .dst_x    (dst_x),
        .dst_y    (dst_y),
        .port_sel (port_sel),
        .arrived  (arrived)
    );

    xy_link_index #(
        .MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW), .LW(LW)
    ) u_link (
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .port_sel (port_sel),
        .link     (link)
    );

endmodule

// File: rtl/path_monitor.sv
// Counts hops of one path, checks strict rise of link numbers and
// compares the final count with the expected length.
// Assumes clear and hop_fire are never high together.
module path_monitor #(
    parameter int LW = 4,
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hop_fire,
    input  logic [LW-1:0] link,
    input  logic          finish,
    input  logic [HW-1:0] expected_len,
    output logic [HW-1:0] hop_count,
    output logic          violation,
    output logic          mismatch
);

    logic [HW-1:0] hop_q;
    logic [LW-1:0] prev_link_q;
    logic          have_prev_q;
    logic          viol_q;
    logic          mism_q;

    // Hop counter and last link number of the current path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hop_q       <= '0;
            prev_link_q <= '0;
            have_prev_q <= 1'b0;
        end else if (clear) begin
            hop_q       <= '0;
            prev_link_q <= '0;
            have_prev_q <= 1'b0;
        end else if (hop_fire) begin
            hop_q       <= hop_q + HW'(1);
            prev_link_q <= link;
            have_prev_q <= 1'b1;
        end
    end

    // Sticky ordering flag, cleared by a new path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if (clear) begin
            viol_q <= 1'b0;
        end else if (hop_fire && have_prev_q && (link <= prev_link_q)) begin
            viol_q <= 1'b1;
        end
    end

    // Length comparison at the end of a path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
        end else if (clear) begin
            mism_q <= 1'b0;
        end else if (finish) begin
            mism_q <= (hop_q != expected_len);
        end
    end

    assign hop_count = hop_q;
    assign violation = viol_q;
    assign mismatch  = mism_q;

endmodule

// File: rtl/mesh_xy_walker.sv
// Hop-sequencing wrapper: loads a source/destination pair and steps the
// header one hop per cycle using the XY route unit until it arrives.
// Assumes all coordinates are inside the MESH_X by MESH_Y mesh.
module mesh_xy_walker
    import mesh_route_pkg::*;
#(
    parameter int MESH_X = 6,
    parameter int MESH_Y = 5,
    localparam int XW = (MESH_X > 2) ? $clog2(MESH_X) : 1,
    localparam int YW = (MESH_Y > 2) ? $clog2(MESH_Y) : 1,
    localparam int LW = $clog2(MESH_X + MESH_Y),
    localparam int HW = $clog2(MESH_X + MESH_Y - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] src_x,
    input  logic [YW-1:0] src_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output logic          busy,
    output logic          done,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y,
    output logic          hop_valid,
    output logic [2:0]    out_port,
    output logic [LW-1:0] link_num,
    output logic [HW-1:0] hop_count,
    output logic          path_mismatch,
    output logic          order_violation
);

    logic          busy_q;
    logic          done_q;
    logic [XW-1:0] cur_x_q;
    logic [YW-1:0] cur_y_q;
    logic [XW-1:0] dst_x_q;
    logic [YW-1:0] dst_y_q;
    logic [HW-1:0] exp_len_q;

    port_e         port_sel;
    logic          arrived;
    logic [LW-1:0] link;
    logic          accept;
    logic          hop_fire;
    logic          finish;
    logic [XW-1:0] dx_abs;
    logic [YW-1:0] dy_abs;

    xy_route_unit #(
        .MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW), .LW(LW)
    ) u_route (
        .cur_x    (cur_x_q),
        .cur_y    (cur_y_q),
        .dst_x    (dst_x_q),
        .dst_y    (dst_y_q),
        .port_sel (port_sel),
        .arrived  (arrived),
        .link     (link)
    );

    // Handshake decode: new path, hop, arrival.
    always_comb begin
        accept   = start && !busy_q;
        hop_fire = busy_q && !arrived;
        finish   = busy_q && arrived;
    end

    // Manhattan distance of the incoming request.
    always_comb begin
        dx_abs = (src_x > dst_x) ? (src_x - dst_x) : (dst_x - src_x);
        dy_abs = (src_y > dst_y) ? (src_y - dst_y) : (dst_y - src_y);
    end

    // Path control: busy and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                busy_q <= 1'b1;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Destination and expected length, captured on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_x_q   <= '0;
            dst_y_q   <= '0;
            exp_len_q <= '0;
        end else if (accept) begin
            dst_x_q   <= dst_x;
            dst_y_q   <= dst_y;
            exp_len_q <= HW'(dx_abs) + HW'(dy_abs);
        end
    end

    // Header position: load the source, then move one step per hop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x_q <= '0;
            cur_y_q <= '0;
        end else if (accept) begin
            cur_x_q <= src_x;
            cur_y_q <= src_y;
        end else if (hop_fire) begin
            unique case (port_sel)
                PORT_XPOS: cur_x_q <= cur_x_q + XW'(1);
                PORT_XNEG: cur_x_q <= cur_x_q - XW'(1);
                PORT_YPOS: cur_y_q <= cur_y_q + YW'(1);
                PORT_YNEG: cur_y_q <= cur_y_q - YW'(1);
                default:   cur_x_q <= cur_x_q;
            endcase
        end
    end

    path_monitor #(.LW(LW), .HW(HW)) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (accept),
        .hop_fire     (hop_fire),
        .link         (link),
        .finish       (finish),
        .expected_len (exp_len_q),
        .hop_count    (hop_count),
        .violation    (order_violation),
        .mismatch     (path_mismatch)
    );

    assign busy      = busy_q;
    assign done      = done_q;
    assign cur_x     = cur_x_q;
    assign cur_y     = cur_y_q;
    assign hop_valid = hop_fire;
    assign out_port  = port_sel;
    assign link_num  = link;

endmodule

// File: rtl/mesh_xy_walker_chk.sv
// Protocol and ordering properties of mesh_xy_walker, attached by bind.
module mesh_xy_walker_chk #(
    parameter int XW = 3,
    parameter int YW = 3,
    parameter int LW = 4,
    parameter int HW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          hop_valid,
    input logic [XW-1:0] cur_x,
    input logic [YW-1:0] cur_y,
    input logic [XW-1:0] dst_x,
    input logic [YW-1:0] dst_y,
    input logic [2:0]    out_port,
    input logic [LW-1:0] link_num,
    input logic [HW-1:0] hop_count,
    input logic [HW-1:0] exp_len,
    input logic          path_mismatch
);

    AST_X_BEFORE_Y: assert property (@(posedge clk) disable iff (!rst_n)
        hop_valid && (out_port == 3'd3 || out_port == 3'd4) |-> cur_x == dst_x); // R1

    AST_Y_TOWARD_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        hop_valid && out_port == 3'd3 |-> cur_y < dst_y); // R2

    AST_LOCAL_AT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cur_x == dst_x && cur_y == dst_y |-> out_port == 3'd0 && !hop_valid); // R3

    AST_DONE_AFTER_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !hop_valid |=> done && !busy); // R3

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hop_valid |=> ((cur_x != $past(cur_x)) != (cur_y != $past(cur_y)))); // R4

    AST_IDLE_NO_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !hop_valid); // R4

    AST_LINK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        hop_valid && $past(hop_valid) |-> link_num > $past(link_num)); // R7

    AST_LENGTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hop_count == exp_len && !path_mismatch); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(dst_x) && $stable(dst_y)); // R9

endmodule

bind mesh_xy_walker mesh_xy_walker_chk #(
    .XW(XW), .YW(YW), .LW(LW), .HW(HW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .hop_valid     (hop_valid),
    .cur_x         (cur_x),
    .cur_y         (cur_y),
    .dst_x         (dst_x_q),
    .dst_y         (dst_y_q),
    .out_port      (out_port),
    .link_num      (link_num),
    .hop_count     (hop_count),
    .exp_len       (exp_len_q),
    .path_mismatch (path_mismatch)
);

// File: tb/mesh_xy_walker_test.sv
// Self-checking bench for mesh_xy_walker on a 6 by 5 mesh.
module mesh_xy_walker_test;

    localparam int MX = 6;
    localparam int MY = 5;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int LW = 4;
    localparam int HW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [XW-1:0] src_x = '0;
    logic [YW-1:0] src_y = '0;
    logic [XW-1:0] dst_x = '0;
    logic [YW-1:0] dst_y = '0;
    logic          busy;
    logic          done;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;
    logic          hop_valid;
    logic [2:0]    out_port;
    logic [LW-1:0] link_num;
    logic [HW-1:0] hop_count;
    logic          path_mismatch;
    logic          order_violation;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mesh_xy_walker #(.MESH_X(MX), .MESH_Y(MY)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .src_x           (src_x),
        .src_y           (src_y),
        .dst_x           (dst_x),
        .dst_y           (dst_y),
        .busy            (busy),
        .done            (done),
        .cur_x           (cur_x),
        .cur_y           (cur_y),
        .hop_valid       (hop_valid),
        .out_port        (out_port),
        .link_num        (link_num),
        .hop_count       (hop_count),
        .path_mismatch   (path_mismatch),
        .order_violation (order_violation)
    );

    // Expected port code from the XY rule (R1, R2, R3).
    function automatic int exp_port(int cx, int cy, int dx, int dy);
        if (cx < dx) return 1;
        if (cx > dx) return 2;
        if (cy < dy) return 3;
        if (cy > dy) return 4;
        return 0;
    endfunction

    // Expected link number for a hop (R5, R6).
    function automatic int exp_link(int cx, int cy, int p);
        case (p)
            1: return cx + 1;
            2: return MX - cx - 1;
            3: return cy + MX;
            4: return MX + MY - cy;
            default: return 0;
        endcase
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Walk one path; optionally fire a second start mid-path (R9).
    task automatic run_path(input int sx, input int sy, input int dx, input int dy,
                            input bit inject);
        int mx, my, p, plen, cycles, prev_link;
        bit seen_prev;
        plen = iabs(sx - dx) + iabs(sy - dy);
        @(negedge clk);
        src_x = XW'(sx); src_y = YW'(sy); dst_x = XW'(dx); dst_y = YW'(dy);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: position loaded from source one edge after start
        check(cur_x == XW'(sx) && cur_y == YW'(sy), "R11 load", int'(cur_x), sx);
        mx = sx; my = sy; cycles = 0; seen_prev = 0; prev_link = -1;
        while (!done && cycles < 64) begin
            p = exp_port(mx, my, dx, dy);
            check(cur_x == XW'(mx) && cur_y == YW'(my), "R4 position", int'(cur_y), my);
            if (p == 1 || p == 2)
                check(int'(out_port) == p, "R1 x port", int'(out_port), p);
            else if (p != 0)
                check(int'(out_port) == p, "R2 y port", int'(out_port), p);
            else
                check(out_port == 3'd0 && !hop_valid, "R3 local", int'(out_port), 0);
            if (p != 0) begin
                check(hop_valid == 1'b1, "R4 hop_valid", int'(hop_valid), 1);
                if (p <= 2)
                    check(int'(link_num) == exp_link(mx, my, p), "R5 x link",
                          int'(link_num), exp_link(mx, my, p));
                else
                    check(int'(link_num) == exp_link(mx, my, p), "R6 y link",
                          int'(link_num), exp_link(mx, my, p));
                if (seen_prev)
                    check(int'(link_num) > prev_link, "R7 rising", int'(link_num), prev_link + 1);
                prev_link = int'(link_num);
                seen_prev = 1;
                case (p)
                    1: mx++;
                    2: mx--;
                    3: my++;
                    default: my--;
                endcase
            end
            if (inject && cycles == 1) begin
                src_x = XW'((sx + 2) % MX); src_y = YW'((sy + 1) % MY);
                dst_x = XW'((dx + 3) % MX); dst_y = YW'((dy + 2) % MY);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        check(done == 1'b1 && cycles == plen + 1, "R4 cycles to done", cycles, plen + 1);
        check(!busy, "R3 busy falls", int'(busy), 0);
        check(int'(hop_count) == plen, inject ? "R9 hop count" : "R8 hop count",
              int'(hop_count), plen);
        check(cur_x == XW'(dx) && cur_y == YW'(dy),
              inject ? "R9 destination kept" : "R3 at destination", int'(cur_x), dx);
        check(!path_mismatch, "R8 mismatch", int'(path_mismatch), 0);
        check(!order_violation, "R7 violation", int'(order_violation), 0);
        @(negedge clk);
        check(!done, "R3 done pulse", int'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h00c0ffee);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !done, "R10 idle", int'(busy), 0);
        check(hop_count == '0, "R10 hop count", int'(hop_count), 0);
        check(!path_mismatch && !order_violation, "R10 flags",
              int'(path_mismatch) + int'(order_violation), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_path(0, 0, MX - 1, MY - 1, 0);   // corner to corner, rising directions
        run_path(MX - 1, MY - 1, 0, 0, 0);   // reverse, reaches top link number
        run_path(2, 2, 2, 2, 0);             // R11 zero length
        run_path(0, 3, MX - 1, 3, 0);        // X only
        run_path(3, 0, 3, MY - 1, 0);        // Y only
        run_path(MX - 1, 0, 0, MY - 1, 0);   // -X then +Y
        run_path(0, MY - 1, MX - 1, 0, 1);   // R9 start during path

        for (int i = 0; i < 40; i++) begin
            run_path(int'($urandom % MX), int'($urandom % MY),
                     int'($urandom % MX), int'($urandom % MY), (i % 5) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule